// File: doc/BRIEF.md
# Chip-Select-Strobed Asynchronous SRAM Controller

This block connects a simple single-cycle request host port to an asynchronous 128K x 8 static RAM. Every RAM access is framed by the active-low chip select. The controller registers the host's address, write flag and write data when it accepts a request. It then runs a fixed sequence of phases: address setup, chip-select strobe, hold, and precharge. Parameters set the length of each phase in clock cycles. At the end it pulses a one-cycle done signal.

Between accesses the chip select always goes high for a precharge interval. The chip select is never held low across two addresses, because the RAM latches a new address only after the select has been high for a minimum time. During idle and precharge the active-high chip enable is low, which turns off the RAM's decoders and input buffers. The controller drives the shared data bus only while it writes. It registers read data on the last cycle of the strobe, so the RAM's access time has passed before the sample is taken.

Top module: `sram_cs_ctrl`

## Requirements
- R1: After reset, and while idle, memCsN, memOeN and memWeN are 1 and memCe and hostDone are 0. A reset asserted in the middle of an access returns the memory controls to this state.
- R2: A request sampled while idle produces exactly one hostDone pulse, one cycle wide. It becomes visible SETUP_CYC+STROBE_CYC+HOLD_CYC+PRECH_CYC clock edges after the edge that sampled the request.
- R3: memCsN goes low exactly once per access and stays low for exactly STROBE_CYC consecutive cycles.
- R4: While memCsN is low, memCe is 1 and memAddr does not change. memCe and the address are valid for at least SETUP_CYC cycles before memCsN falls.
- R5: Between two low intervals of memCsN, memCsN is high for at least HOLD_CYC+PRECH_CYC+SETUP_CYC cycles.
- R6: For a write (hostWrite=1), memWeN is 0 and memOeN is 1 throughout the strobe. memData carries the request's write data, and that byte is stored at the request's address.
- R7: For a read (hostWrite=0), memOeN is 0 and memWeN is 1 during the strobe, and the controller does not drive memData. hostRdata takes the bus value from the last strobe cycle, so a value present only in the first strobe cycle is never returned.
- R8: hostRdata holds its value until the next read completes; write accesses leave it unchanged.
- R9: hostReq is ignored while an access is in progress: it causes no extra strobe, no write and no extra done pulse.
- R10: memOeN and memWeN are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Access request, sampled only while idle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 17 | Word address |
| hostWdata | input | 8 | Byte to write |
| hostRdata | output | 8 | Byte from the last completed read |
| hostDone | output | 1 | One-cycle pulse at the end of each access |
| memAddr | output | 17 | RAM address bus |
| memData | inout | 8 | RAM data bus, driven by the controller only during writes |
| memCsN | output | 1 | RAM chip select, active low, strobes every access |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memCe | output | 1 | RAM chip enable, active high |

## Verification
The RAM model drives a garbage byte in the first strobe cycle and the real byte only after that. A controller that samples read data too early therefore returns the garbage value. Requests are issued back to back, the moment each done pulse appears. A controller that shortens or skips the precharge is caught by the bench's count of chip-select high time. A second request pulsed in the middle of an access must leave no trace: if it is not ignored, it shows up as an extra strobe, an extra done pulse, or a byte written to the wrong location. Two further checks cover stale state: read data must survive a later write, and a reset during a strobe must release the memory controls at once.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_PRECH
  } phase_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadReq;   // register host request fields
    logic ceOn;      // chip enable high
    logic csLow;     // chip select asserted
    logic oeLow;     // output enable asserted
    logic weLow;     // write enable asserted
    logic driveBus;  // controller drives memData
    logic capture;   // register read data
  } memStrb_t;

endpackage

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int PRECH_CYC  = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostReq,
  input  logic     hostWrite,
  output memStrb_t strb,
  output logic     hostDone
);

  localparam int MAX_AB = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_CD = (HOLD_CYC > PRECH_CYC) ? HOLD_CYC : PRECH_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;
  logic             doneQ;
  logic             lastCyc;

  assign lastCyc = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (hostReq) begin
            phase   <= PH_SETUP;
            cnt     <= CNT_W'(SETUP_CYC - 1);
            isWrite <= hostWrite;
          end
        end
        PH_SETUP: begin
          if (lastCyc) begin
            phase <= PH_STROBE;
            cnt   <= CNT_W'(STROBE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (lastCyc) begin
            phase <= PH_HOLD;
            cnt   <= CNT_W'(HOLD_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (lastCyc) begin
            phase <= PH_PRECH;
            cnt   <= CNT_W'(PRECH_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_PRECH: begin
          if (lastCyc) begin
            phase <= PH_IDLE;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadReq  = (phase == PH_IDLE) && hostReq;
    strb.ceOn     = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    strb.csLow    = (phase == PH_STROBE);
    strb.oeLow    = (phase == PH_STROBE) && !isWrite;
    strb.weLow    = isWrite && ((phase == PH_SETUP) || (phase == PH_STROBE));
    strb.driveBus = isWrite && ((phase == PH_STROBE) || (phase == PH_HOLD));
    strb.capture  = (phase == PH_STROBE) && lastCyc && !isWrite;
  end

  assign hostDone = doneQ;

  // R2: done never lasts longer than one cycle
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

  // R9: a request seen while busy does not restart the sequence
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && phase != PH_SETUP) |=> (phase != PH_SETUP));

  // R5: the select always stays high after a strobe ends
  assert_precharge_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.csLow) |=> !strb.csLow);

endmodule

// File: rtl/sramc_dpath.sv
module sramc_dpath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrb_t          strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memCe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strb.loadReq) begin
        addrQ  <= hostAddr;
        wdataQ <= hostWdata;
      end
      if (strb.capture) begin
        rdataQ <= memData;
      end
    end
  end

  assign memData   = strb.driveBus ? wdataQ : {DATA_W{1'bz}};
  assign memAddr   = addrQ;
  assign hostRdata = rdataQ;
  assign memCsN    = ~strb.csLow;
  assign memOeN    = ~strb.oeLow;
  assign memWeN    = ~strb.weLow;
  assign memCe     = strb.ceOn;

  // R4: the address is frozen while the select is low
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  // R4: select low only with chip enable high
  assert_cs_needs_ce_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> memCe);

  // R7: never drive the bus while the RAM outputs are enabled
  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.driveBus |-> memOeN);

  // R10: output and write enables exclusive
  assert_oe_we_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

endmodule

// File: rtl/sram_cs_ctrl.sv
module sram_cs_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int PRECH_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostDone,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memCe
);

  memStrb_t strb;

  sramc_seq #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .PRECH_CYC (PRECH_CYC)
  ) uSeq (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .strb     (strb),
    .hostDone (hostDone)
  );

  sramc_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata),
    .memAddr  (memAddr),
    .memData  (memData),
    .memCsN   (memCsN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memCe    (memCe)
  );

endmodule

// File: tb/tb_sram_cs_ctrl.sv
`timescale 1ns/1ps
module tb_sram_cs_ctrl;

  localparam int S = 1, T = 3, H = 1, P = 2;
  localparam int EXP_WAIT = S + T + H + P + 1;
  localparam int NVEC = 11;
  // {write, addr[16:0], data-or-expected[7:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 17'h00000, 8'hA5},
    {1'b1, 17'h1FFFF, 8'h3C},
    {1'b0, 17'h00000, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h3C},
    {1'b1, 17'h0AAAA, 8'h00},
    {1'b1, 17'h15555, 8'hFF},
    {1'b0, 17'h15555, 8'hFF},
    {1'b0, 17'h0AAAA, 8'h00},
    {1'b1, 17'h00000, 8'h5E},
    {1'b0, 17'h00000, 8'h5E},
    {1'b0, 17'h12345, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic [16:0] hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic        hostDone;
  logic [16:0] memAddr;
  wire  [7:0]  memData;
  logic        memCsN, memOeN, memWeN, memCe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sram_cs_ctrl dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostDone(hostDone), .memAddr(memAddr), .memData(memData),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memCe(memCe)
  );

  // RAM model: garbage in the first strobe cycle, real data afterwards
  logic [7:0] ram [logic [16:0]];
  logic [7:0] ramOut;
  logic       ramDrv;
  int         strobeAge = 0;

  always @(posedge clk) begin
    if (memCsN) strobeAge <= 0;
    else        strobeAge <= strobeAge + 1;
    if (memCe && !memCsN && !memWeN) ram[memAddr] = memData;
  end

  always_comb begin
    if (strobeAge == 0)         ramOut = 8'hEE;
    else if (ram.exists(memAddr)) ramOut = ram[memAddr];
    else                        ramOut = 8'h5A;
  end
  assign ramDrv  = memCe && !memCsN && !memOeN && memWeN;
  assign memData = ramDrv ? ramOut : 8'hzz;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Protocol monitor
  logic        curWrite = 1'b0;
  logic [7:0]  curData = '0;
  int          csLowRun = 0, csHighRun = 0, ceRun = 0, csFalls = 0;
  bit          sawLow = 0;
  logic [16:0] lowAddr = '0;
  int          monErr = 0;

  task automatic monFail(input string tag, input int act, input int expv);
    monErr++;
    errors++;
    $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      csLowRun = 0; csHighRun = 0; ceRun = 0; sawLow = 0;
    end else begin
      if (!memCsN) begin
        if (!memCe) monFail("R4 ce low under select", 0, 1);
        if (csLowRun > 0 && memAddr != lowAddr) monFail("R4 address moved in strobe", memAddr, lowAddr);
        if (csLowRun == 0) begin
          lowAddr = memAddr;
          csFalls++;
          if (ceRun < S) monFail("R4 setup before select", ceRun, S);
          if (sawLow && csHighRun < H + P + S) monFail("R5 precharge gap", csHighRun, H + P + S);
        end
        csLowRun++;
        csHighRun = 0;
        if (curWrite) begin
          if (memWeN || !memOeN) monFail("R6 write enables", {memWeN, memOeN}, 2'b01);
          if (memData !== curData) monFail("R6 write bus", memData, curData);
        end else begin
          if (memOeN || !memWeN) monFail("R7 read enables", {memWeN, memOeN}, 2'b10);
        end
      end else begin
        if (csLowRun > 0 && csLowRun != T) monFail("R3 strobe width", csLowRun, T);
        if (csLowRun > 0) sawLow = 1;
        csLowRun = 0;
        csHighRun++;
      end
      ceRun = memCe ? ceRun + 1 : 0;
      if (!memOeN && !memWeN) monFail("R10 oe and we both low", 0, 1);
    end
  end

  // Issue one access and measure latency
  task automatic access(input logic w, input logic [16:0] a, input logic [7:0] d, output int waited);
    hostReq = 1'b1; hostWrite = w; hostAddr = a; hostWdata = d;
    curWrite = w; curData = d;
    waited = 0;
    while (waited < 200) begin
      @(negedge clk);
      waited++;
      if (waited == 1) hostReq = 1'b0;
      if (hostDone) break;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int waited;
    int falls0;
    int dones;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(memCsN && memOeN && memWeN && !memCe && !hostDone, "R1 reset outputs",
        {memCsN, memOeN, memWeN, memCe, hostDone}, 5'b11100);
    rstN = 1'b1;
    @(negedge clk);
    chk(memCsN && !memCe, "R1 idle after reset", {memCsN, memCe}, 2'b10);

    for (int i = 0; i < NVEC; i++) begin
      logic        w;
      logic [16:0] a;
      logic [7:0]  d;
      w = VEC[i][25]; a = VEC[i][24:8]; d = VEC[i][7:0];
      falls0 = csFalls;
      access(w, a, d, waited);
      chk(waited == EXP_WAIT, "R2 done latency", waited, EXP_WAIT);
      chk(memCsN && !memCe && memOeN && memWeN, "R1 idle at done",
          {memCsN, memCe, memOeN, memWeN}, 4'b1011);
      chk(csFalls == falls0 + 1, "R3 one strobe per access", csFalls, falls0 + 1);
      if (!w) chk(hostRdata == d, "R7 read data from last strobe cycle", hostRdata, d);
      else    chk(ram.exists(a) && ram[a] == d, "R6 byte stored", ram.exists(a) ? ram[a] : 8'hxx, d);
      @(negedge clk);
      chk(!hostDone, "R2 done one cycle", hostDone, 0);
    end

    // R8: a write leaves read data unchanged
    access(1'b1, 17'h0AAAA, 8'h77, waited);
    chk(hostRdata == 8'h5A, "R8 rdata held over write", hostRdata, 8'h5A);
    @(negedge clk);

    // R9: a request while busy is ignored
    falls0 = csFalls;
    dones = 0;
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = 17'h15555; curWrite = 1'b0;
    for (int c = 1; c <= 2 * EXP_WAIT; c++) begin
      @(negedge clk);
      hostReq = 1'b0;
      if (c == 3) begin
        hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 17'h00000; hostWdata = 8'h11;
      end
      if (hostDone) dones++;
    end
    hostReq = 1'b0;
    chk(dones == 1, "R9 single done", dones, 1);
    chk(csFalls == falls0 + 1, "R9 single strobe", csFalls, falls0 + 1);
    chk(hostRdata == 8'hFF, "R9 original read completed", hostRdata, 8'hFF);
    access(1'b0, 17'h00000, 8'h00, waited);
    chk(hostRdata == 8'h5E, "R9 no stray write", hostRdata, 8'h5E);
    @(negedge clk);

    // R1: reset in the middle of a strobe
    hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 17'h01234; hostWdata = 8'h99;
    curWrite = 1'b1; curData = 8'h99;
    @(negedge clk); hostReq = 1'b0;
    @(negedge clk);
    chk(!memCsN, "R1 strobe reached before reset", memCsN, 0);
    rstN = 1'b0;
    @(negedge clk);
    chk(memCsN && memOeN && memWeN && !memCe && !hostDone, "R1 reset mid-access",
        {memCsN, memOeN, memWeN, memCe, hostDone}, 5'b11100);
    rstN = 1'b1;
    repeat (2 * EXP_WAIT) @(negedge clk);
    chk(memCsN && !memCe, "R1 stays idle after reset", {memCsN, memCe}, 2'b10);

    chk(monErr == 0, "R3 R4 R5 R6 R7 R10 protocol monitor", monErr, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule